// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Atomics

This block gives a group of CPU ports that share one memory a way to do atomic read-modify-write sequences without locking anyone out. A port issues a reserving load, which returns data and arms that port's private reservation: a lock bit plus the index of the 64-bit block it touched. Later, the port issues a conditional store. The store reaches memory only if the reservation survived. Any write from another port that lands anywhere in the reserved block disarms the reservation. The issuing port receives a pass or fail flag, and on a fail the software simply retries the sequence.

The shared memory is modelled inside the block as a small array of 64-bit blocks. Every port may also issue ordinary 32-bit or 64-bit loads and stores. All ports may present requests in the same cycle. The requests are then resolved in port-index order: port 0 first, then port 1, and so on. Each request sees the memory and reservation state left by the requests with a lower index. Every request gets a response exactly one cycle later.

Top module: `lrsc_monitor`

## Requirements
- R1: An aligned reserving load (op code 2) returns the addressed data and arms the issuing port's lock on the 64-bit block that holds the address. A later conditional store by that port to either half of the same block can therefore pass.
- R2: A conditional store (op code 3) writes memory and returns sc_ok=1 only when the issuing port's lock is armed on the same block. Otherwise it returns sc_ok=0 and memory is unchanged. A conditional store with no earlier reserving load fails.
- R3: A write by another port (an ordinary store or a passing conditional store) of either size to any part of a reserved block disarms that reservation.
- R4: Every aligned conditional store disarms the issuing port's lock, whether it passes or fails. A second conditional store without a new reserving load fails.
- R5: A reserving load or conditional store that is not naturally aligned raises align_err. Such an access returns zero data, writes nothing and leaves every reservation as it was. A 64-bit access must have address bits [2:0] zero; a 32-bit access must have bits [1:0] zero.
- R6: Requests in the same cycle are resolved in fixed priority, with the lowest port index first. A write by a higher-priority port disarms the reservations of lower-priority ports before their conditional stores in that cycle are judged. A load sees the writes of higher-priority ports in the same cycle.
- R7: Ordinary loads (op 0) and stores (op 1) use size 1 for 64 bits and size 0 for 32 bits. A 32-bit access selects the upper half of the block when address bit 2 is 1. Its data travels in bits [31:0], and bits [63:32] of the read result are zero. Ordinary accesses ignore address bits below their size.
- R8: Each response is valid exactly one cycle after its request, and rsp_valid is low after an idle cycle. After reset the memory reads as zero, no lock is armed, and all outputs are zero.
- R9: A port's own ordinary store to its reserved block does not disarm its own reservation.
- R10: A port holds one reservation. A new reserving load moves it to the new block, so a later conditional store to the old block fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Request present, one bit per port |
| req_op | input | 2*NPORT | Per-port op: 0 load, 1 store, 2 reserving load, 3 conditional store |
| req_size | input | NPORT | Per-port size: 0 is 32 bits, 1 is 64 bits |
| req_addr | input | ADDR_W*NPORT | Per-port byte address |
| req_wdata | input | 64*NPORT | Per-port store data (32-bit data in bits [31:0]) |
| rsp_valid | output | NPORT | Response present, one cycle after the request |
| rsp_rdata | output | 64*NPORT | Read data for loads and reserving loads, else zero |
| rsp_sc_ok | output | NPORT | Conditional store passed and wrote memory |
| rsp_align_err | output | NPORT | Misaligned reserving load or conditional store |

## Verification
The reservation logic is driven with single-port reserve/store sequences, once with no interference and once with a store of the other size from a second port. This tells a reservation that survives apart from one that a partial overlap kills. Same-cycle patterns separate the two possible orderings: two ports racing on one block, and a high-priority store against a low-priority conditional store and the reverse. These show whether the arbitration order is applied before the judgement or after it. Misaligned attempts and repeated or redirected conditional stores show whether the lock is left alone, dropped, or moved in each of those cases.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_RSV   = 2'd2,
      OP_COND  = 2'd3
   } lrsc_op_e;

   localparam int BLK_BITS  = 64;
   localparam int LANE_BITS = 32;
   localparam int LANES     = BLK_BITS / LANE_BITS;

   // Decoded access, as seen by the storage model.
   typedef struct packed {
      logic                 rd;     // returns data (load or reserving load)
      logic                 wide;   // 64-bit access
      logic                 hi;     // upper lane for a 32-bit access
      logic [LANES-1:0]     lanes;  // lanes a write would touch
      logic [BLK_BITS-1:0]  wdat;   // write data placed on its lanes
   } acc_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode #(
   parameter int ADDR_W = 7,
   localparam int IDX_W = ADDR_W - 3
) (
   input  logic                 valid,
   input  logic [1:0]           op,
   input  logic                 size,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [63:0]          wdata,
   output lrsc_pkg::acc_t       acc,
   output logic [IDX_W-1:0]     blk,
   output logic                 is_st,
   output logic                 is_lr,
   output logic                 is_sc,
   output logic                 is_mis
);
   import lrsc_pkg::*;

   logic atomic, off_size;

   always_comb begin
      atomic   = (op == OP_RSV) || (op == OP_COND);
      off_size = size ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);

      is_st  = valid && (op == OP_STORE);
      is_lr  = valid && (op == OP_RSV)  && !off_size;
      is_sc  = valid && (op == OP_COND) && !off_size;
      is_mis = valid && atomic && off_size;

      blk       = addr[ADDR_W-1:3];
      acc.rd    = (valid && (op == OP_LOAD)) || is_lr;
      acc.wide  = size;
      acc.hi    = addr[2];
      acc.lanes = size ? 2'b11 : (addr[2] ? 2'b10 : 2'b01);
      acc.wdat  = size ? wdata : {wdata[31:0], wdata[31:0]};
   end

endmodule

// File: rtl/lrsc_order.sv
module lrsc_order #(
   parameter int NPORT = 4,
   parameter int IDX_W = 4
) (
   input  logic [NPORT-1:0]              is_st,
   input  logic [NPORT-1:0]              is_lr,
   input  logic [NPORT-1:0]              is_sc,
   input  logic [NPORT-1:0][IDX_W-1:0]   blk,
   input  logic [NPORT-1:0]              lock_q,
   input  logic [NPORT-1:0][IDX_W-1:0]   rblk_q,
   output logic [NPORT-1:0]              lock_d,
   output logic [NPORT-1:0][IDX_W-1:0]   rblk_d,
   output logic [NPORT-1:0]              wr_en,
   output logic [NPORT-1:0]              sc_ok
);

   logic [NPORT-1:0]            lk;
   logic [NPORT-1:0][IDX_W-1:0] rb;

   // Ports are resolved one after another in index order; each stage
   // sees the reservation state left by the stages before it.
   always_comb begin
      lk    = lock_q;
      rb    = rblk_q;
      wr_en = '0;
      sc_ok = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (is_lr[p]) begin
            lk[p] = 1'b1;
            rb[p] = blk[p];
         end
         if (is_sc[p]) begin
            sc_ok[p] = lk[p] && (rb[p] == blk[p]);
            lk[p]    = 1'b0;
         end
         wr_en[p] = is_st[p] || sc_ok[p];
         if (wr_en[p]) begin
            for (int q = 0; q < NPORT; q++) begin
               if (q != p && lk[q] && rb[q] == blk[p]) lk[q] = 1'b0;
            end
         end
      end
      lock_d = lk;
      rblk_d = rb;
   end

   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         a_r2_pass_needs_cond: assert (!sc_ok[p] || is_sc[p]);
      end
   end

endmodule

// File: rtl/lrsc_store.sv
module lrsc_store #(
   parameter int NPORT = 4,
   parameter int IDX_W = 4,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  lrsc_pkg::acc_t [NPORT-1:0]    acc,
   input  logic [NPORT-1:0][IDX_W-1:0]   blk,
   input  logic [NPORT-1:0]              wr_en,
   output logic [NPORT-1:0][63:0]        rd
);
   import lrsc_pkg::*;

   logic [BLK_BITS-1:0] mem [DEPTH];
   logic [BLK_BITS-1:0] view;

   // Writes land in port order, so a later port's lanes end up on top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p]) begin
               for (int l = 0; l < LANES; l++) begin
                  if (acc[p].lanes[l])
                     mem[blk[p]][l*LANE_BITS +: LANE_BITS] <= acc[p].wdat[l*LANE_BITS +: LANE_BITS];
               end
            end
         end
      end
   end

   // Reads see the block as left by all higher-priority writes this cycle.
   always_comb begin
      rd = '0;
      for (int p = 0; p < NPORT; p++) begin
         view = mem[blk[p]];
         for (int q = 0; q < NPORT; q++) begin
            if (q < p && wr_en[q] && blk[q] == blk[p]) begin
               for (int l = 0; l < LANES; l++) begin
                  if (acc[q].lanes[l])
                     view[l*LANE_BITS +: LANE_BITS] = acc[q].wdat[l*LANE_BITS +: LANE_BITS];
               end
            end
         end
         if (acc[p].rd) begin
            if (acc[p].wide) rd[p] = view;
            else             rd[p] = {32'd0, acc[p].hi ? view[63:32] : view[31:0]};
         end
      end
   end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
   parameter int NPORT  = 4,
   parameter int ADDR_W = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORT-1:0]         req_valid,
   input  logic [2*NPORT-1:0]       req_op,
   input  logic [NPORT-1:0]         req_size,
   input  logic [ADDR_W*NPORT-1:0]  req_addr,
   input  logic [64*NPORT-1:0]      req_wdata,
   output logic [NPORT-1:0]         rsp_valid,
   output logic [64*NPORT-1:0]      rsp_rdata,
   output logic [NPORT-1:0]         rsp_sc_ok,
   output logic [NPORT-1:0]         rsp_align_err
);
   import lrsc_pkg::*;

   localparam int IDX_W = ADDR_W - 3;

   if (NPORT < 1 || NPORT > 8) begin : g_bad_nport
      $error("lrsc_monitor: NPORT must be 1..8");
   end
   if (ADDR_W < 4 || ADDR_W > 12) begin : g_bad_addr
      $error("lrsc_monitor: ADDR_W must be 4..12");
   end

   acc_t [NPORT-1:0]             acc;
   logic [NPORT-1:0][IDX_W-1:0]  blk;
   logic [NPORT-1:0]             is_st, is_lr, is_sc, is_mis;
   logic [NPORT-1:0]             lock_q, lock_d, wr_en, sc_ok;
   logic [NPORT-1:0][IDX_W-1:0]  rblk_q, rblk_d;
   logic [NPORT-1:0][63:0]       rd;
   logic [NPORT-1:0][63:0]       rdata_q;
   logic [NPORT-1:0]             sc_q;

   for (genvar p = 0; p < NPORT; p++) begin : g_dec
      lrsc_decode #(.ADDR_W(ADDR_W)) u_dec (
         .valid  (req_valid[p]),
         .op     (req_op[2*p +: 2]),
         .size   (req_size[p]),
         .addr   (req_addr[ADDR_W*p +: ADDR_W]),
         .wdata  (req_wdata[64*p +: 64]),
         .acc    (acc[p]),
         .blk    (blk[p]),
         .is_st  (is_st[p]),
         .is_lr  (is_lr[p]),
         .is_sc  (is_sc[p]),
         .is_mis (is_mis[p])
      );
   end

   lrsc_order #(.NPORT(NPORT), .IDX_W(IDX_W)) u_order (
      .is_st  (is_st),
      .is_lr  (is_lr),
      .is_sc  (is_sc),
      .blk    (blk),
      .lock_q (lock_q),
      .rblk_q (rblk_q),
      .lock_d (lock_d),
      .rblk_d (rblk_d),
      .wr_en  (wr_en),
      .sc_ok  (sc_ok)
   );

   lrsc_store #(.NPORT(NPORT), .IDX_W(IDX_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (acc),
      .blk   (blk),
      .wr_en (wr_en),
      .rd    (rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q        <= '0;
         rblk_q        <= '0;
         rsp_valid     <= '0;
         rdata_q       <= '0;
         rsp_sc_ok     <= '0;
         rsp_align_err <= '0;
         sc_q          <= '0;
      end else begin
         lock_q        <= lock_d;
         rblk_q        <= rblk_d;
         rsp_valid     <= req_valid;
         rdata_q       <= rd;
         rsp_sc_ok     <= sc_ok;
         rsp_align_err <= is_mis;
         sc_q          <= is_sc;
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rsp
      assign rsp_rdata[64*p +: 64] = rdata_q[p];

      a_r4_cond_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
         is_sc[p] |=> !lock_q[p]);
      a_r1_rsv_arms_lock: assert property (@(posedge clk) disable iff (!rst_n)
         (is_lr[p] && wr_en == '0) |=> (lock_q[p] && rblk_q[p] == $past(blk[p])));
      a_r5_misaligned_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
         (is_mis[p] && wr_en == '0 && is_lr == '0 && is_sc == '0) |=> $stable(lock_q[p]));
      a_r5_err_never_passes: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_align_err[p] |-> !rsp_sc_ok[p]);
      a_r2_pass_from_cond: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_sc_ok[p] |-> (sc_q[p] && rsp_valid[p]));
      a_r8_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid[p] |=> rsp_valid[p]);
   end

endmodule

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int AW = 7;

   localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NP-1:0]     req_valid;
   logic [2*NP-1:0]   req_op;
   logic [NP-1:0]     req_size;
   logic [AW*NP-1:0]  req_addr;
   logic [64*NP-1:0]  req_wdata;
   logic [NP-1:0]     rsp_valid;
   logic [64*NP-1:0]  rsp_rdata;
   logic [NP-1:0]     rsp_sc_ok;
   logic [NP-1:0]     rsp_align_err;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   lrsc_monitor #(.NPORT(NP), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok),
      .rsp_align_err(rsp_align_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic clr();
      req_valid = '0; req_op = '0; req_size = '0; req_addr = '0; req_wdata = '0;
   endtask

   task automatic put(int p, logic [1:0] op, logic sz, logic [AW-1:0] a, logic [63:0] d);
      req_valid[p]           = 1'b1;
      req_op[2*p +: 2]       = op;
      req_size[p]            = sz;
      req_addr[AW*p +: AW]   = a;
      req_wdata[64*p +: 64]  = d;
   endtask

   // Requests are applied at a falling edge; the registered response is
   // read at the next falling edge, then the inputs are cleared.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go1(int p, logic [1:0] op, logic sz, logic [AW-1:0] a, logic [63:0] d);
      clr(); put(p, op, sz, a, d); step(); clr();
   endtask

   function automatic logic [63:0] rd(int p);
      return rsp_rdata[64*p +: 64];
   endfunction

   task automatic t_reset();
      chk("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R8 reset rdata", rsp_rdata[63:0], 64'd0);
      go1(0, LD, 1'b1, 7'd0, 64'd0);
      chk("R8 reset memory", rd(0), 64'd0);
   endtask

   task automatic t_plain();
      go1(0, ST, 1'b1, 7'd8, 64'h1111_2222_3333_4444);
      chk("R8 valid next cycle", 64'(rsp_valid[0]), 64'd1);
      chk("R7 store no pass", 64'(rsp_sc_ok[0]), 64'd0);
      go1(0, LD, 1'b1, 7'd8, 64'd0);
      chk("R7 load64", rd(0), 64'h1111_2222_3333_4444);
      go1(1, LD, 1'b0, 7'd12, 64'd0);
      chk("R7 load32 upper", rd(1), 64'h0000_0000_1111_2222);
      go1(1, LD, 1'b0, 7'd13, 64'd0);
      chk("R7 low bits ignored", rd(1), 64'h0000_0000_1111_2222);
      go1(1, ST, 1'b0, 7'd8, 64'hFFFF_FFFF_AAAA_5555);
      go1(2, LD, 1'b1, 7'd8, 64'd0);
      chk("R7 store32 lower lane", rd(2), 64'h1111_2222_AAAA_5555);
      clr(); step();
      chk("R8 idle no valid", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_lrsc();
      go1(1, LR, 1'b1, 7'd16, 64'd0);
      chk("R1 rsv data", rd(1), 64'd0);
      chk("R1 rsv no err", 64'(rsp_align_err[1]), 64'd0);
      go1(1, SC, 1'b1, 7'd16, 64'hD1D1_0000_0000_D1D1);
      chk("R2 cond pass", 64'(rsp_sc_ok[1]), 64'd1);
      go1(0, LD, 1'b1, 7'd16, 64'd0);
      chk("R2 cond wrote", rd(0), 64'hD1D1_0000_0000_D1D1);
      go1(2, SC, 1'b1, 7'd16, 64'hBAD0);
      chk("R2 cond without rsv fails", 64'(rsp_sc_ok[2]), 64'd0);
      go1(0, LD, 1'b1, 7'd16, 64'd0);
      chk("R2 failed cond no write", rd(0), 64'hD1D1_0000_0000_D1D1);
      go1(0, LR, 1'b0, 7'd40, 64'd0);
      go1(0, SC, 1'b0, 7'd44, 64'h0000_0000_0000_7777);
      chk("R1 other half of block passes", 64'(rsp_sc_ok[0]), 64'd1);
   endtask

   task automatic t_conflict();
      go1(2, LR, 1'b1, 7'd24, 64'd0);
      go1(3, ST, 1'b0, 7'd28, 64'h0000_0000_CAFE_F00D);
      go1(2, SC, 1'b1, 7'd24, 64'h3333_3333_3333_3333);
      chk("R3 overlap write kills rsv", 64'(rsp_sc_ok[2]), 64'd0);
      go1(0, LD, 1'b1, 7'd24, 64'd0);
      chk("R3 memory holds other write", rd(0), 64'hCAFE_F00D_0000_0000);
   endtask

   task automatic t_once();
      go1(0, LR, 1'b0, 7'd36, 64'd0);
      go1(0, SC, 1'b0, 7'd36, 64'h1234);
      chk("R4 first cond pass", 64'(rsp_sc_ok[0]), 64'd1);
      go1(0, SC, 1'b0, 7'd36, 64'h5678);
      chk("R4 second cond fails", 64'(rsp_sc_ok[0]), 64'd0);
      go1(1, LD, 1'b0, 7'd36, 64'd0);
      chk("R4 memory from first cond", rd(1), 64'h1234);
   endtask

   task automatic t_misal();
      go1(1, LR, 1'b1, 7'd48, 64'd0);
      go1(1, LR, 1'b0, 7'd58, 64'd0);
      chk("R5 misaligned rsv err", 64'(rsp_align_err[1]), 64'd1);
      chk("R5 misaligned rsv data zero", rd(1), 64'd0);
      go1(1, SC, 1'b1, 7'd52, 64'hEEEE);
      chk("R5 misaligned cond err", 64'(rsp_align_err[1]), 64'd1);
      chk("R5 misaligned cond fails", 64'(rsp_sc_ok[1]), 64'd0);
      go1(2, LD, 1'b1, 7'd48, 64'd0);
      chk("R5 misaligned cond no write", rd(2), 64'd0);
      go1(1, SC, 1'b1, 7'd48, 64'h4444_0000_4444_0000);
      chk("R5 rsv kept after misaligned", 64'(rsp_sc_ok[1]), 64'd1);
      go1(2, LD, 1'b1, 7'd48, 64'd0);
      chk("R5 then cond wrote", rd(2), 64'h4444_0000_4444_0000);
   endtask

   task automatic t_race();
      clr(); put(0, LR, 1'b1, 7'd64, 64'd0); put(1, LR, 1'b1, 7'd64, 64'd0); step();
      clr(); put(0, SC, 1'b1, 7'd64, 64'hE0E0); put(1, SC, 1'b1, 7'd64, 64'hE1E1); step();
      chk("R6 race high prio pass", 64'(rsp_sc_ok[0]), 64'd1);
      chk("R6 race low prio fail", 64'(rsp_sc_ok[1]), 64'd0);
      go1(2, LD, 1'b1, 7'd64, 64'd0);
      chk("R6 race winner data", rd(2), 64'hE0E0);
      clr(); put(0, ST, 1'b1, 7'd72, 64'hF0F0_F0F0); put(2, LD, 1'b1, 7'd72, 64'd0); step();
      chk("R6 load sees earlier write", rd(2), 64'hF0F0_F0F0);
      go1(1, LR, 1'b1, 7'd80, 64'd0);
      clr(); put(0, ST, 1'b0, 7'd80, 64'h99); put(1, SC, 1'b1, 7'd80, 64'h6161); step();
      chk("R6 higher store kills cond", 64'(rsp_sc_ok[1]), 64'd0);
      go1(2, LR, 1'b1, 7'd88, 64'd0);
      clr(); put(2, SC, 1'b1, 7'd88, 64'h0000_0002_0000_0002); put(3, ST, 1'b0, 7'd92, 64'h0000_0003);
      step();
      chk("R6 lower store after cond", 64'(rsp_sc_ok[2]), 64'd1);
      go1(0, LD, 1'b1, 7'd88, 64'd0);
      chk("R6 write order", rd(0), 64'h0000_0003_0000_0002);
   endtask

   task automatic t_own();
      go1(3, LR, 1'b1, 7'd96, 64'd0);
      go1(3, ST, 1'b1, 7'd96, 64'h77);
      go1(3, SC, 1'b1, 7'd96, 64'h88);
      chk("R9 own store keeps rsv", 64'(rsp_sc_ok[3]), 64'd1);
   endtask

   task automatic t_move();
      go1(0, LR, 1'b1, 7'd104, 64'd0);
      go1(0, LR, 1'b1, 7'd112, 64'd0);
      go1(0, SC, 1'b1, 7'd104, 64'hABCD);
      chk("R10 old block cond fails", 64'(rsp_sc_ok[0]), 64'd0);
      go1(1, LD, 1'b1, 7'd104, 64'd0);
      chk("R10 old block untouched", rd(1), 64'd0);
   endtask

   initial begin
      clr();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_lrsc();
      t_conflict();
      t_once();
      t_misal();
      t_race();
      t_own();
      t_move();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

endmodule